// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block takes one request to process `n` elements and turns it into a series of vector commands. Each command covers at most `MVL` elements, with a default `MVL` of 64. Software or a scalar front end gives a single start pulse with an element count and a base element index. The block then hands a downstream vector unit one strip at a time. Each strip carries a start index and a vector length.

The odd-sized piece goes first. The opening strip carries `n mod MVL` elements, and every later strip carries a full `MVL`. When the count is an exact multiple of `MVL`, no empty strip is sent, and the sequence begins with a full strip. Each command is offered on a valid/ready handshake. The block then waits for a separate completion pulse from the vector unit before it offers the next strip. A single-cycle finish pulse marks the end of the whole request.

Top module: `strip_sequencer`

## Requirements
- R1: When `n mod MVL` is nonzero, the first strip issued has length `n mod MVL`.
- R2: Every strip after the first has length exactly `MVL`.
- R3: The first strip starts at the base index. Each later strip starts at the previous start index plus the previous length, modulo 2^IDX_W.
- R4: A request issues `floor(n/MVL)` strips, plus one more when `n mod MVL` is nonzero, and the strip lengths sum to `n`.
- R5: While `cmd_valid_o` is high and `cmd_ready_i` is low, the command stays asserted and its index and length do not change.
- R6: After a strip is accepted, `cmd_valid_o` stays low until `strip_done_i` is sampled high. The next strip appears in the cycle after that.
- R7: When `n` is zero, `seq_done_o` is high in the cycle after start and no strip is issued.
- R8: `seq_done_o` is a single-cycle pulse. It rises in the cycle after the completion pulse of the last strip is sampled.
- R9: A start pulse given while a request is in progress has no effect, and that includes the cycle in which the finish pulse is high.
- R10: After reset, `cmd_valid_o` and `seq_done_o` are low until a start is accepted.
- R11: When `n` is a nonzero multiple of `MVL`, no zero-length strip is issued, and the first strip has length `MVL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted only when idle |
| count_i | input | CNT_W | Total element count `n` |
| base_i | input | IDX_W | Base element index |
| cmd_valid_o | output | 1 | Strip command offered |
| cmd_ready_i | input | 1 | Downstream accepts the command |
| cmd_index_o | output | IDX_W | Start index of the strip |
| cmd_len_o | output | LEN_W | Vector length of the strip |
| strip_done_i | input | 1 | Downstream finished the accepted strip |
| seq_done_o | output | 1 | All strips complete (one-cycle pulse) |

## Verification
A wrong internal state shows at the command port on the next offered strip. A bad running index or a stale length makes the very next `cmd_index_o` or `cmd_len_o` differ from the bench's arithmetic. A wrong remaining count shows up later, as an extra strip, a missing strip, or a finish pulse that arrives one strip early or late. A controller that leaves its wait state early shows a valid command before the completion pulse, within the first strip.

// File: rtl/strip_pkg.sv
// Shared definitions for the strip sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package strip_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FINISH = 2'd3
    } seq_state_e;
endpackage

// File: rtl/strip_len_calc.sv
// Computes the length of the opening strip for a count.
// The length is the remainder count mod MVL, or MVL when the remainder is zero.
// Also flags an empty request.
// Assumes: MVL >= 1 and LEN_W can hold MVL.
module strip_len_calc #(
    parameter int CNT_W = 16,
    parameter int MVL   = 64,
    parameter int LEN_W = $clog2(MVL + 1)
) (
    input  logic [CNT_W-1:0] count_i,
    output logic [LEN_W-1:0] first_len_o,
    output logic             count_zero_o
);
    localparam logic [LEN_W-1:0] MVL_L  = LEN_W'(MVL);
    localparam int               MVL_LG = (MVL > 1) ? $clog2(MVL) : 1;

    logic [LEN_W-1:0] rem;

    generate
        if ((MVL & (MVL - 1)) == 0) begin : g_pow2
            // Remainder by masking the low bits when MVL is a power of two.
            if (MVL == 1) begin : g_one
                always_comb rem = '0;
            end else begin : g_mask
                always_comb rem = LEN_W'(count_i[MVL_LG-1:0]);
            end
        end else begin : g_div
            // General remainder for a non-power-of-two MVL.
            always_comb rem = LEN_W'(count_i % CNT_W'(MVL));
        end
    endgenerate

    // Select the remainder, or a full strip when the remainder is zero.
    always_comb begin
        count_zero_o = (count_i == '0);
        first_len_o  = (rem == '0) ? MVL_L : rem;
    end
endmodule

// File: rtl/strip_track.sv
// Datapath holding the running start index, the elements still to issue
// and the length of the current strip.
// Assumes: load and advance are never high together.
module strip_track #(
    parameter int CNT_W = 16,
    parameter int IDX_W = 20,
    parameter int MVL   = 64,
    parameter int LEN_W = $clog2(MVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             advance_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [IDX_W-1:0] base_i,
    input  logic [LEN_W-1:0] first_len_i,
    output logic [IDX_W-1:0] index_o,
    output logic [LEN_W-1:0] len_o,
    output logic             last_strip_o
);
    localparam logic [LEN_W-1:0] MVL_L = LEN_W'(MVL);

    logic [CNT_W-1:0] remain_q;

    // Load a new request, or step past the strip that just completed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            index_o  <= '0;
            len_o    <= '0;
        end else if (load_i) begin
            remain_q <= count_i;
            index_o  <= base_i;
            len_o    <= first_len_i;
        end else if (advance_i) begin
            remain_q <= remain_q - CNT_W'(len_o);
            index_o  <= index_o + IDX_W'(len_o);
            len_o    <= MVL_L;
        end
    end

    // The current strip is the last one when it covers everything left.
    always_comb last_strip_o = (remain_q == CNT_W'(len_o));
endmodule

// File: rtl/strip_ctrl.sv
// Control FSM: offers each strip, waits for the downstream completion,
// and pulses the finish flag.
// Assumes: strip_done_i arrives only after a strip was accepted.
module strip_ctrl
    import strip_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       count_zero_i,
    input  logic       cmd_ready_i,
    input  logic       strip_done_i,
    input  logic       last_strip_i,
    output seq_state_e state_o,
    output logic       load_o,
    output logic       advance_o,
    output logic       cmd_valid_o,
    output logic       seq_done_o
);
    seq_state_e state_d;

    // Next-state and strobe decode.
    always_comb begin
        state_d   = state_o;
        load_o    = 1'b0;
        advance_o = 1'b0;
        unique case (state_o)
            ST_IDLE: if (start_i) begin
                load_o  = 1'b1;
                state_d = count_zero_i ? ST_FINISH : ST_ISSUE;
            end
            ST_ISSUE: if (cmd_ready_i) state_d = ST_WAIT;
            ST_WAIT: if (strip_done_i) begin
                advance_o = 1'b1;
                state_d   = last_strip_i ? ST_FINISH : ST_ISSUE;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_o <= ST_IDLE;
        else        state_o <= state_d;
    end

    // Outputs decoded from the state.
    always_comb begin
        cmd_valid_o = (state_o == ST_ISSUE);
        seq_done_o  = (state_o == ST_FINISH);
    end
endmodule

// File: rtl/strip_sequencer.sv
// Top of the strip-mining sequencer. It splits an n-element request into
// an odd-sized leading strip followed by full MVL strips.
// Assumes: the downstream unit signals completion once per accepted strip.
module strip_sequencer #(
    parameter int CNT_W = 16,
    parameter int IDX_W = 20,
    parameter int MVL   = 64,
    parameter int LEN_W = $clog2(MVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [IDX_W-1:0] base_i,
    output logic             cmd_valid_o,
    input  logic             cmd_ready_i,
    output logic [IDX_W-1:0] cmd_index_o,
    output logic [LEN_W-1:0] cmd_len_o,
    input  logic             strip_done_i,
    output logic             seq_done_o
);
    import strip_pkg::*;

    seq_state_e       state;
    logic             load, advance, last_strip, count_zero;
    logic [LEN_W-1:0] first_len;

    strip_len_calc #(.CNT_W(CNT_W), .MVL(MVL), .LEN_W(LEN_W)) u_len (
        .count_i      (count_i),
        .first_len_o  (first_len),
        .count_zero_o (count_zero)
    );

    strip_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .count_zero_i (count_zero),
        .cmd_ready_i  (cmd_ready_i),
        .strip_done_i (strip_done_i),
        .last_strip_i (last_strip),
        .state_o      (state),
        .load_o       (load),
        .advance_o    (advance),
        .cmd_valid_o  (cmd_valid_o),
        .seq_done_o   (seq_done_o)
    );

    strip_track #(.CNT_W(CNT_W), .IDX_W(IDX_W), .MVL(MVL), .LEN_W(LEN_W)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .advance_i    (advance),
        .count_i      (count_i),
        .base_i       (base_i),
        .first_len_i  (first_len),
        .index_o      (cmd_index_o),
        .len_o        (cmd_len_o),
        .last_strip_o (last_strip)
    );
endmodule

// File: rtl/strip_seq_checker.sv
// Port-level protocol checks for strip_sequencer, attached by bind.
// Keeps its own view of busy/first-strip state built from port activity.
module strip_seq_checker #(
    parameter int CNT_W = 16,
    parameter int IDX_W = 20,
    parameter int MVL   = 64,
    parameter int LEN_W = $clog2(MVL + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [CNT_W-1:0] count_i,
    input logic             cmd_valid_o,
    input logic             cmd_ready_i,
    input logic [IDX_W-1:0] cmd_index_o,
    input logic [LEN_W-1:0] cmd_len_o,
    input logic             seq_done_o
);
    logic             busy_q, took_one_q;
    logic [IDX_W-1:0] next_idx_q;

    // Observer state: request in flight, a strip already taken, expected next index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            took_one_q <= 1'b0;
            next_idx_q <= '0;
        end else begin
            if (start_i && !busy_q) begin
                busy_q     <= 1'b1;
                took_one_q <= 1'b0;
            end else if (seq_done_o) begin
                busy_q <= 1'b0;
            end
            if (cmd_valid_o && cmd_ready_i) begin
                took_one_q <= 1'b1;
                next_idx_q <= cmd_index_o + IDX_W'(cmd_len_o);
            end
        end
    end

    a_r5_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_index_o) && $stable(cmd_len_o));
    a_r2_full_later: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && took_one_q |-> cmd_len_o == LEN_W'(MVL));
    a_r3_index_chain: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && took_one_q |-> cmd_index_o == next_idx_q);
    a_r11_no_empty: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> cmd_len_o != '0 && cmd_len_o <= LEN_W'(MVL));
    a_r6_wait_done: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && cmd_ready_i |=> !cmd_valid_o);
    a_r7_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_q && count_i == '0 |=> seq_done_o && !cmd_valid_o);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_o |=> !seq_done_o);
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !cmd_valid_o && !seq_done_o);
endmodule

bind strip_sequencer strip_seq_checker #(
    .CNT_W(CNT_W), .IDX_W(IDX_W), .MVL(MVL), .LEN_W(LEN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .count_i     (count_i),
    .cmd_valid_o (cmd_valid_o),
    .cmd_ready_i (cmd_ready_i),
    .cmd_index_o (cmd_index_o),
    .cmd_len_o   (cmd_len_o),
    .seq_done_o  (seq_done_o)
);

// File: tb/sim_strip_sequencer.sv
// Bench: directed corners plus seeded random requests, checked against
// expected strips computed from the requirements.
module sim_strip_sequencer;
    localparam int CNT_W = 16;
    localparam int IDX_W = 20;
    localparam int MVL   = 64;
    localparam int LEN_W = $clog2(MVL + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] count_i = '0;
    logic [IDX_W-1:0] base_i = '0;
    logic             cmd_ready_i = 1'b0;
    logic             strip_done_i = 1'b0;
    logic             cmd_valid_o, seq_done_o;
    logic [IDX_W-1:0] cmd_index_o;
    logic [LEN_W-1:0] cmd_len_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    strip_sequencer #(.CNT_W(CNT_W), .IDX_W(IDX_W), .MVL(MVL)) u0 (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_strips(input int n);
        return n / MVL + ((n % MVL) != 0 ? 1 : 0);
    endfunction

    function automatic int exp_len(input int n, input int k);
        if (k == 0 && (n % MVL) != 0) return n % MVL;
        return MVL;
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    // One full request; poke injects a second start mid-run (R9).
    task automatic run_req(input int n, input logic [IDX_W-1:0] base, input bit poke);
        logic [IDX_W-1:0] idx = base;
        int               sum = 0;
        int               got = 0;
        int               ns  = exp_strips(n);
        @(negedge clk);
        start_i = 1; count_i = CNT_W'(n); base_i = base;
        @(negedge clk);
        start_i = 0; count_i = CNT_W'($urandom_range(0, 500)); base_i = IDX_W'($urandom);
        if (n == 0) begin
            chk(seq_done_o === 1'b1, "R7 done after start", seq_done_o, 1);
            chk(cmd_valid_o === 1'b0, "R7 no strip", cmd_valid_o, 0);
        end
        for (int k = 0; k < ns; k++) begin
            int hold = $urandom_range(0, 3);
            int dly  = $urandom_range(0, 4);
            logic [LEN_W-1:0] l0;
            logic [IDX_W-1:0] i0;
            chk(cmd_valid_o === 1'b1, "R6 strip offered", cmd_valid_o, 1);
            chk(cmd_len_o == LEN_W'(exp_len(n, k)), k == 0 ? "R1/R11 first len" : "R2 later len",
                cmd_len_o, exp_len(n, k));
            chk(cmd_index_o == idx, "R3 start index", cmd_index_o, idx);
            l0 = cmd_len_o; i0 = cmd_index_o;
            for (int h = 0; h < hold; h++) begin
                if (poke && h == 0) begin start_i = 1; count_i = 16'd7; base_i = '0; end
                @(negedge clk);
                start_i = 0;
                chk(cmd_valid_o === 1'b1 && cmd_len_o == l0 && cmd_index_o == i0,
                    "R5 hold stable", cmd_index_o, i0);
            end
            cmd_ready_i = 1;
            @(negedge clk);
            cmd_ready_i = 0;
            got++; sum += int'(l0); idx = idx + IDX_W'(l0);
            for (int d = 0; d < dly; d++) begin
                chk(cmd_valid_o === 1'b0 && seq_done_o === 1'b0, "R6 wait for done", cmd_valid_o, 0);
                @(negedge clk);
            end
            strip_done_i = 1;
            @(negedge clk);
            strip_done_i = 0;
        end
        chk(got == ns && sum == n, "R4 strip count and total", sum, n);
        chk(seq_done_o === 1'b1, "R8 finish pulse", seq_done_o, 1);
        chk(cmd_valid_o === 1'b0, "R8 no strip with finish", cmd_valid_o, 0);
        // Start during the finish cycle must be ignored (R9).
        start_i = poke; count_i = 16'd5; base_i = '0;
        @(negedge clk);
        start_i = 0;
        chk(seq_done_o === 1'b0, "R8 pulse one cycle", seq_done_o, 0);
        chk(cmd_valid_o === 1'b0, "R9 late start ignored", cmd_valid_o, 0);
        @(negedge clk);
        chk(cmd_valid_o === 1'b0 && seq_done_o === 1'b0, "R9 still idle", cmd_valid_o, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(cmd_valid_o === 1'b0 && seq_done_o === 1'b0, "R10 reset quiet", cmd_valid_o, 0);
        rst_n = 1;
        @(negedge clk);
        chk(cmd_valid_o === 1'b0 && seq_done_o === 1'b0, "R10 idle after reset", seq_done_o, 0);
        run_req(0, 20'h00010, 1);
        run_req(1, 20'h00100, 0);
        run_req(63, 20'h00200, 1);
        run_req(64, 20'h00300, 0);
        run_req(65, 20'h00400, 1);
        run_req(128, 20'h00500, 1);
        run_req(200, 20'hFFFF0, 1);
        for (int t = 0; t < 40; t++)
            run_req($urandom_range(0, 330), IDX_W'($urandom), 1'($urandom));
        finish_run();
    end
endmodule